// File: doc/BRIEF.md
# Core Memory Word Line Decoder

This block takes a word address and turns it into the line selects for a magnetic core stack. It holds the address in a register, gates some of the register bits with two timing strobes, and feeds a set of one-of-eight decoders. Each decoder drives four switch or driver pairs on one axis of the stack. The X axis has switch decoders and driver decoders, and so does the Y axis. Every output is active low, and at most one line in each group is low at a time.

The read/write flag goes into every decoder as an input of its own. Because of this, one address selects the same switch or driver position on a read and on a write. The read line sits in outputs 0–3 of the decoder and its write partner sits four places higher. A mode input chooses between the 4K-word and 8K-word stacks. In 4K mode the top address bit is captured as zero, so half of the X switch decoders never fire.

The read flag and both timing strobes act combinationally on the outputs. The address only changes on a capture edge.

Top module: `core_word_decoder`

## Requirements
- R1: On a rising `clk` edge with `cap_en` high, the register takes {A13..A02 from `bus_addr`, A01 from `a01`}. With `cap_en` low it holds its value. A synchronous low `rst_n` clears it to zero.
- R2: When `mode_8k` is low, A13 is captured as 0 whatever `bus_addr[13]` is. When `mode_8k` is high, A13 is captured from the bus.
- R3: The switch strobe is active when (`rd` and `t_rd`) or (not `rd` and `t_wr`). When it is inactive, every bit of `x_sw_n` and `y_sw_n` is 1.
- R4: The driver strobe is active when (`rd` and `t_wr`) or (not `rd` and `t_rd`). When it is inactive, every bit of `x_drv_n` and `y_drv_n` is 1.
- R5: Each output group is a set of 8-bit decoder slices; slice k occupies bits [8k+7:8k]. In the enabled slice, the one low bit is at index 4*(not `rd`) + 2*hi + lo, where hi and lo are the two pair-select bits named below.
- R6: Y switches: the slice is A06, and the pair select is hi=A02, lo=A01.
- R7: Y drivers: the slice is A03, and the pair select is hi=A05, lo=A04.
- R8: X switches: the slice is {A13,A12}, which gives four slices, and the pair select is hi=A08, lo=A07.
- R9: X drivers: the slice is A09, and the pair select is hi=A11, lo=A10.
- R10: In each of the four groups at most one bit is low. When `t_rd` and `t_wr` are both low, all outputs are high.
- R11: For the same captured address with both strobes high, the write selects equal the read selects with the two nibbles of each slice swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_en | input | 1 | Load the address register on this edge |
| bus_addr | input | 12 | Address bits A13..A02 (index 13 down to 2) |
| a01 | input | 1 | Forwarded A01 bit |
| mode_8k | input | 1 | 1: 8K words, 0: 4K words |
| rd | input | 1 | 1: read cycle, 0: write cycle |
| t_rd | input | 1 | Read-timing strobe |
| t_wr | input | 1 | Write-timing strobe |
| y_sw_n | output | 16 | Y switch lines, 2 slices, active low |
| y_drv_n | output | 16 | Y driver lines, 2 slices, active low |
| x_sw_n | output | 32 | X switch lines, 4 slices, active low |
| x_drv_n | output | 16 | X driver lines, 2 slices, active low |

## Verification
Switch selection and driver selection can be active in the same cycle. Whether they are depends only on how the read flag pairs with the two timing strobes. The bench sets all eight combinations of `rd`, `t_rd` and `t_wr` on one fixed address. For each combination it checks that each side is fully active or fully idle as R3 and R4 predict.

It then sweeps every address in both modes with both strobes high. Each address is decoded first as a read and then as a write without recapturing, which confirms that the two directions land on the same positions.

// File: rtl/cwd_pkg.sv
// Shared sizes for the core word decoder.
// Assumes the fixed geometry of 4-line-pair decoders with a direction input.
package cwd_pkg;
    localparam int ADDR_W   = 13;              // A13..A01
    localparam int DEC_OUT  = 8;               // lines per decoder slice
    localparam int PAIR_W   = 2;               // pair select bits
    localparam int Y_SW_DEC = 2;
    localparam int Y_DR_DEC = 2;
    localparam int X_SW_DEC = 4;
    localparam int X_DR_DEC = 2;
endpackage

// File: rtl/cwd_addr_reg.sv
// Word address register. It loads on the clock edge when the capture
// enable is high and has only a synchronous clear. In 4K mode the top
// bit is forced to zero. Bit k of q holds address bit A(k+1).
module cwd_addr_reg
    import cwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              mode_8k,
    input  logic [13:2]       bus_addr,
    input  logic              a01,
    output logic [ADDR_W-1:0] q
);
    logic top_bit;

    // Pick the source of A13 according to the stack size.
    always_comb top_bit = mode_8k ? bus_addr[13] : 1'b0;

    // Capture the word address; no asynchronous set or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (cap_en)
            q <= {top_bit, bus_addr[12:2], a01};
    end

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(q));
    // R2
    small_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en && !mode_8k) |=> !q[ADDR_W-1]);
endmodule

// File: rtl/cwd_gate.sv
// Strobe and block-enable network. It forms the switch and driver
// strobes from the direction flag and the timing strobes, then qualifies
// the block-select bits with them. All block enables are active low.
module cwd_gate
    import cwd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd,
    input  logic                t_rd,
    input  logic                t_wr,
    input  logic                a03,
    input  logic                a06,
    input  logic                a09,
    input  logic [1:0]          a13_12,
    output logic [Y_SW_DEC-1:0] ysw_blk_n,
    output logic [Y_DR_DEC-1:0] ydr_blk_n,
    output logic [X_SW_DEC-1:0] xsw_blk_n,
    output logic [X_DR_DEC-1:0] xdr_blk_n
);
    logic sw_en, dr_en;

    // Switch strobe follows the timing of the current direction.
    always_comb sw_en = (rd & t_rd) | (~rd & t_wr);
    // Driver strobe uses the opposite timing pairing.
    always_comb dr_en = (rd & t_wr) | (~rd & t_rd);

    generate
        for (genvar k = 0; k < Y_SW_DEC; k++) begin : g_ysw
            // Y switch slice k enabled when A06 equals k.
            always_comb ysw_blk_n[k] = ~(sw_en & (a06 == k[0]));
        end
        for (genvar k = 0; k < Y_DR_DEC; k++) begin : g_ydr
            // Y driver slice k enabled when A03 equals k.
            always_comb ydr_blk_n[k] = ~(dr_en & (a03 == k[0]));
        end
        for (genvar k = 0; k < X_SW_DEC; k++) begin : g_xsw
            // X switch slice k enabled for one A13/A12 combination.
            always_comb xsw_blk_n[k] = ~(sw_en & (a13_12 == k[1:0]));
        end
        for (genvar k = 0; k < X_DR_DEC; k++) begin : g_xdr
            // X driver slice k enabled when A09 equals k.
            always_comb xdr_blk_n[k] = ~(dr_en & (a09 == k[0]));
        end
    endgenerate

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!t_rd && !t_wr) |-> (&ysw_blk_n && &ydr_blk_n && &xsw_blk_n && &xdr_blk_n));
    // R3
    sw_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~xsw_blk_n) && $onehot0(~ysw_blk_n));
endmodule

// File: rtl/cwd_dec8.sv
// One-of-eight decoder slice. When the active-low block select is low,
// exactly the line {rd_n, sel} is driven low. Otherwise all lines are high.
module cwd_dec8
    import cwd_pkg::*;
(
    input  logic [PAIR_W-1:0]  sel,
    input  logic               rd_n,
    input  logic               blk_n,
    output logic [DEC_OUT-1:0] out_n
);
    // Drive the addressed line low when the slice is enabled.
    always_comb begin
        out_n = '1;
        if (!blk_n)
            out_n[{rd_n, sel}] = 1'b0;
    end
endmodule

// File: rtl/core_word_decoder.sv
// Top of the core word line decoder: address register, strobe gating and
// one decoder slice per switch or driver block on each axis. Outputs are
// combinational from the register and the direction and timing inputs.
module core_word_decoder
    import cwd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cap_en,
    input  logic [13:2]                  bus_addr,
    input  logic                         a01,
    input  logic                         mode_8k,
    input  logic                         rd,
    input  logic                         t_rd,
    input  logic                         t_wr,
    output logic [Y_SW_DEC*DEC_OUT-1:0]  y_sw_n,
    output logic [Y_DR_DEC*DEC_OUT-1:0]  y_drv_n,
    output logic [X_SW_DEC*DEC_OUT-1:0]  x_sw_n,
    output logic [X_DR_DEC*DEC_OUT-1:0]  x_drv_n
);
    logic [ADDR_W-1:0]   aq;
    logic [Y_SW_DEC-1:0] ysw_blk_n;
    logic [Y_DR_DEC-1:0] ydr_blk_n;
    logic [X_SW_DEC-1:0] xsw_blk_n;
    logic [X_DR_DEC-1:0] xdr_blk_n;
    logic                rd_n;

    // Direction input shared by every decoder slice.
    always_comb rd_n = ~rd;

    cwd_addr_reg u_areg (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .mode_8k(mode_8k),
        .bus_addr(bus_addr), .a01(a01), .q(aq)
    );

    cwd_gate u_gate (
        .clk(clk), .rst_n(rst_n), .rd(rd), .t_rd(t_rd), .t_wr(t_wr),
        .a03(aq[2]), .a06(aq[5]), .a09(aq[8]), .a13_12(aq[12:11]),
        .ysw_blk_n(ysw_blk_n), .ydr_blk_n(ydr_blk_n),
        .xsw_blk_n(xsw_blk_n), .xdr_blk_n(xdr_blk_n)
    );

    generate
        for (genvar k = 0; k < Y_SW_DEC; k++) begin : g_ysw
            cwd_dec8 u_dec (.sel(aq[1:0]), .rd_n(rd_n), .blk_n(ysw_blk_n[k]),
                            .out_n(y_sw_n[k*DEC_OUT +: DEC_OUT]));
        end
        for (genvar k = 0; k < Y_DR_DEC; k++) begin : g_ydr
            cwd_dec8 u_dec (.sel(aq[4:3]), .rd_n(rd_n), .blk_n(ydr_blk_n[k]),
                            .out_n(y_drv_n[k*DEC_OUT +: DEC_OUT]));
        end
        for (genvar k = 0; k < X_SW_DEC; k++) begin : g_xsw
            cwd_dec8 u_dec (.sel(aq[7:6]), .rd_n(rd_n), .blk_n(xsw_blk_n[k]),
                            .out_n(x_sw_n[k*DEC_OUT +: DEC_OUT]));
        end
        for (genvar k = 0; k < X_DR_DEC; k++) begin : g_xdr
            cwd_dec8 u_dec (.sel(aq[10:9]), .rd_n(rd_n), .blk_n(xdr_blk_n[k]),
                            .out_n(x_drv_n[k*DEC_OUT +: DEC_OUT]));
        end
    endgenerate

    // R10
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~y_sw_n) && $onehot0(~y_drv_n) && $onehot0(~x_sw_n) && $onehot0(~x_drv_n));
    // R5
    sw_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd && t_rd) || (!rd && t_wr)) |-> ($countones(~y_sw_n) == 1 && $countones(~x_sw_n) == 1));
    // R4
    drv_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd && t_wr) || (!rd && t_rd)) |-> ($countones(~y_drv_n) == 1 && $countones(~x_drv_n) == 1));
endmodule

// File: tb/core_word_decoder_tb.sv
module core_word_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_en = 1'b0;
    logic [13:2] bus_addr = '0;
    logic        a01 = 1'b0;
    logic        mode_8k = 1'b1;
    logic        rd = 1'b1;
    logic        t_rd = 1'b0;
    logic        t_wr = 1'b0;
    logic [15:0] y_sw_n, y_drv_n, x_drv_n;
    logic [31:0] x_sw_n;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    core_word_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .bus_addr(bus_addr), .a01(a01),
        .mode_8k(mode_8k), .rd(rd), .t_rd(t_rd), .t_wr(t_wr),
        .y_sw_n(y_sw_n), .y_drv_n(y_drv_n), .x_sw_n(x_sw_n), .x_drv_n(x_drv_n)
    );

    // Expected {x_drv, x_sw, y_drv, y_sw} for word w (bit0 = A01).
    function automatic logic [79:0] expect_vec(input logic [12:0] w, input logic m8,
                                               input logic r, input logic sw, input logic dr);
        logic [15:0] ys, yd, xd;
        logic [31:0] xs;
        logic [12:0] a;
        logic rn;
        a = w;
        if (!m8) a[12] = 1'b0;
        rn = ~r;
        ys = '1; yd = '1; xs = '1; xd = '1;
        if (sw) ys[a[5]*8 + rn*4 + a[1]*2 + a[0]] = 1'b0;                 // R6
        if (dr) yd[a[2]*8 + rn*4 + a[4]*2 + a[3]] = 1'b0;                 // R7
        if (sw) xs[(a[12]*2 + a[11])*8 + rn*4 + a[7]*2 + a[6]] = 1'b0;    // R8
        if (dr) xd[a[8]*8 + rn*4 + a[10]*2 + a[9]] = 1'b0;                // R9
        return {xd, xs, yd, ys};
    endfunction

    function automatic logic [79:0] nib_swap(input logic [79:0] v);
        logic [79:0] o;
        for (int k = 0; k < 10; k++) o[k*8 +: 8] = {v[k*8 +: 4], v[k*8+4 +: 4]};
        return o;
    endfunction

    function automatic logic [79:0] outs();
        return {x_drv_n, x_sw_n, y_drv_n, y_sw_n};
    endfunction

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic capture(input logic [12:0] w);
        @(negedge clk);
        bus_addr = w[12:1]; a01 = w[0]; cap_en = 1'b1;
        @(negedge clk);
        cap_en = 1'b0;
    endtask

    // R1 / R10: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        bus_addr = 12'hFFF; a01 = 1'b1; cap_en = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; cap_en = 1'b0;
        rd = 1'b1; t_rd = 1'b0; t_wr = 1'b0; #1;
        check("R10 idle after reset", outs(), {80{1'b1}});
        t_rd = 1'b1; t_wr = 1'b1; #1;
        check("R1 reset clears register", outs(), expect_vec(13'h0, 1'b1, 1'b1, 1'b1, 1'b1));
        t_rd = 1'b0; t_wr = 1'b0;
    endtask

    // R3 / R4: every direction and strobe combination
    task automatic t_strobes();
        mode_8k = 1'b1;
        capture(13'h1B6D);
        for (int c = 0; c < 8; c++) begin
            logic sw, dr;
            rd = c[2]; t_rd = c[1]; t_wr = c[0]; #1;
            sw = (rd & t_rd) | (~rd & t_wr);
            dr = (rd & t_wr) | (~rd & t_rd);
            check("R3 R4 strobe combination", outs(), expect_vec(13'h1B6D, 1'b1, rd, sw, dr));
        end
        t_rd = 1'b0; t_wr = 1'b0;
    endtask

    // R1: register holds while capture enable is low
    task automatic t_hold();
        capture(13'h0A53);
        bus_addr = 12'h5AC; a01 = 1'b0;
        repeat (3) @(negedge clk);
        rd = 1'b1; t_rd = 1'b1; t_wr = 1'b1; #1;
        check("R1 hold without capture", outs(), expect_vec(13'h0A53, 1'b1, 1'b1, 1'b1, 1'b1));
        t_rd = 1'b0; t_wr = 1'b0;
    endtask

    // R2 R5..R11: every address in one mode, read then write
    task automatic t_sweep(input logic m8);
        mode_8k = m8;
        t_rd = 1'b1; t_wr = 1'b1;
        for (int w = 0; w < 8192; w++) begin
            logic [79:0] rv;
            rd = 1'b1;
            capture(w[12:0]);
            #1;
            rv = outs();
            check("R2 R5 R6 R7 R8 R9 read decode", rv, expect_vec(w[12:0], m8, 1'b1, 1'b1, 1'b1));
            rd = 1'b0; #1;
            check("R5 write decode", outs(), expect_vec(w[12:0], m8, 1'b0, 1'b1, 1'b1));
            check("R11 read/write same position", outs(), nib_swap(rv));
        end
        t_rd = 1'b0; t_wr = 1'b0; rd = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired act=%0d exp<=150000", cycles);
            finish_run();
        end
    end

    initial begin
        t_reset();
        t_strobes();
        t_hold();
        t_sweep(1'b1);
        t_sweep(1'b0);
        finish_run();
    end
endmodule